// File: doc/BRIEF.md
# Two-Level Interrupt Aggregator

The block gathers event pulses from power-management sub-functions, along with four GPIO pins, into nine sticky 8-bit sub-status registers. Each sub-status register has a mask register beside it. An 8-bit main status register condenses the nine into eight summary bits. Main bit 4 covers two sub-registers; every other main bit covers one. A main mask register, kept apart from the sub masks, decides which summary bits may drive the single interrupt line to the host.

The host reaches every register through a plain 8-bit register port made of address, write data, write enable, read enable and read data. There is no back-pressure. A write takes effect at the clock edge where `we_i` is high. A read is accepted at the edge where `re_i` is high, and the data appears on `rdata_o` after that edge. `rdata_o` then holds its value until the next read. Pending bits are cleared by writing ones to the address the host reads them from. Each GPIO pin has its own configuration byte. A 3-bit trigger field in that byte selects rising edge, falling edge, high level or low level detection, or switches detection off. Event and pin inputs are taken to be synchronous to `clk_i` already.

Address map with the default parameters:
- main status: 0x00, read only
- main mask: 0x01
- sub-status s: 0x10+s
- sub-mask s: 0x20+s
- pin n configuration: 0x30+2n

Top module: `irq_aggregator`

## Requirements
- R1: After reset:
  - all sub-status bits and the main status read 0x00;
  - every sub-mask and the main mask read 0xFF, where a mask bit of 1 means masked;
  - every GPIO configuration byte reads 0x00;
  - `irq_o` is low.
- R2: A one-cycle pulse on `evt_i[8*s+b]` sets bit b of sub-status s whether or not that bit is masked. Bits 3..0 of sub-status 7 are also set by detected conditions on GPIO pins 3..0.
- R3: Writing to sub-status address 0x10+s clears exactly the bits written as one. Bits written as zero keep their value, and a pending bit never falls for any other reason.
- R4: When a set (event or GPIO) and a one-written clear reach the same bit in the same cycle, the bit stays set.
- R5: A main status bit reads 1 exactly when a sub-register it covers holds a pending bit whose sub-mask bit is 0.
- R6: Main bits 0..3 cover sub-registers 0..3. Main bit 4 covers sub-registers 4 and 5 together. Main bits 5, 6 and 7 cover sub-registers 6, 7 and 8.
- R7: `irq_o` is high exactly when some main status bit is 1 and its bit in the main mask (0x01) is 0. It follows status and mask changes in the cycle after the updating edge.
- R8: Pin n's trigger field is bits 6..4 of its configuration byte at 0x30+2n. Byte value 0x20 selects rising edge and 0x10 selects falling edge. An edge sets sub-status 7 bit n once; a steady pin sets nothing.
- R9: Byte value 0x40 selects high level and 0x50 selects low level. The pin's bit is set again in every cycle the level persists, so it cannot be cleared while the level is held.
- R10: Any other value of the trigger field turns off detection for that pin. Configuration bytes read back exactly as written.
- R11: A read with `re_i` high at an edge places the addressed register on `rdata_o` after that edge. Unmapped addresses read 0x00, and writes to the main status address have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | 72 | Event pulses, bit 8*s+b targets sub-status s bit b |
| gpio_i | input | 4 | GPIO pin levels, synchronous |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write enable |
| re_i | input | 1 | Read enable |
| rdata_o | output | 8 | Read data, registered |
| irq_o | output | 1 | Active-high interrupt to host |

## Verification
The hardest situation to reach from the ports is a clear that lands in the same cycle as a set. The bench produces it two ways. First, it raises an event pulse in the very cycle of a one-written acknowledge. Second, it holds a level-configured pin at its active level while acknowledging, so the set is present in every cycle. The bench also has to show that main bit 4 stays high while either of its two sub-registers still holds an unmasked bit. It arms both sub-registers and then retires them one at a time, reading the main status in between.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int DW        = 8;
  localparam int NUM_SUB   = 9;
  localparam int NUM_MAIN  = 8;
  localparam int NUM_GPIO  = 4;
  localparam int GPIO_SUB  = 7;
  localparam int EVT_W     = NUM_SUB * DW;
  localparam int TRIG_LSB  = 4;
  localparam int TRIG_W    = 3;

  localparam logic [TRIG_W-1:0] TRIG_FALL = 3'b001;
  localparam logic [TRIG_W-1:0] TRIG_RISE = 3'b010;
  localparam logic [TRIG_W-1:0] TRIG_HIGH = 3'b100;
  localparam logic [TRIG_W-1:0] TRIG_LOW  = 3'b101;

  // Which sub-registers a main status bit summarizes (bit i set = covers sub i)
  function automatic logic [NUM_SUB-1:0] main_cover(input int j);
    logic [NUM_SUB-1:0] c;
    c = '0;
    if (j < 4)       c[j]   = 1'b1;
    else if (j == 4) begin
      c[4] = 1'b1;
      c[5] = 1'b1;
    end
    else             c[j+1] = 1'b1;
    return c;
  endfunction
endpackage

// File: rtl/irqagg_gpio_detect.sv
module irqagg_gpio_detect
  import irqagg_pkg::*;
(
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_GPIO-1:0]           pin_i,
  input  logic [NUM_GPIO-1:0][DW-1:0]   cfg_i,
  output logic [NUM_GPIO-1:0]           hit_o
);
  logic [NUM_GPIO-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= pin_i;
  end

  for (genvar p = 0; p < NUM_GPIO; p++) begin : g_pin
    logic [TRIG_W-1:0] trig;
    assign trig = cfg_i[p][TRIG_LSB +: TRIG_W];
    always_comb begin
      case (trig)
        TRIG_RISE: hit_o[p] =  pin_i[p] & ~prev_q[p];
        TRIG_FALL: hit_o[p] = ~pin_i[p] &  prev_q[p];
        TRIG_HIGH: hit_o[p] =  pin_i[p];
        TRIG_LOW:  hit_o[p] = ~pin_i[p];
        default:   hit_o[p] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/irqagg_status_bank.sv
module irqagg_status_bank
  import irqagg_pkg::*;
(
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_SUB-1:0][DW-1:0]   set_i,
  input  logic [NUM_SUB-1:0][DW-1:0]   clr_i,
  input  logic [NUM_SUB-1:0]           mask_we_i,
  input  logic [DW-1:0]                mask_wdata_i,
  output logic [NUM_SUB-1:0][DW-1:0]   stat_o,
  output logic [NUM_SUB-1:0][DW-1:0]   mask_o
);
  for (genvar s = 0; s < NUM_SUB; s++) begin : g_sub
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stat_o[s] <= '0;
        mask_o[s] <= '1;
      end else begin
        // a set in the same cycle as its clear wins
        stat_o[s] <= (stat_o[s] & ~clr_i[s]) | set_i[s];
        if (mask_we_i[s]) mask_o[s] <= mask_wdata_i;
      end
    end
  end
endmodule

// File: rtl/irqagg_summary.sv
module irqagg_summary
  import irqagg_pkg::*;
(
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_SUB-1:0][DW-1:0]   stat_i,
  input  logic [NUM_SUB-1:0][DW-1:0]   mask_i,
  input  logic                         main_mask_we_i,
  input  logic [DW-1:0]                wdata_i,
  output logic [NUM_MAIN-1:0]          main_stat_o,
  output logic [NUM_MAIN-1:0]          main_mask_o,
  output logic                         irq_o
);
  logic [NUM_SUB-1:0] sub_any;

  for (genvar s = 0; s < NUM_SUB; s++) begin : g_any
    assign sub_any[s] = |(stat_i[s] & ~mask_i[s]);
  end

  for (genvar j = 0; j < NUM_MAIN; j++) begin : g_main
    localparam logic [NUM_SUB-1:0] COVER = main_cover(j);
    assign main_stat_o[j] = |(sub_any & COVER);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             main_mask_o <= '1;
    else if (main_mask_we_i) main_mask_o <= wdata_i;
  end

  assign irq_o = |(main_stat_o & ~main_mask_o);
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irqagg_pkg::*;
#(
  parameter logic [7:0] MAIN_STAT_ADDR = 8'h00,
  parameter logic [7:0] MAIN_MASK_ADDR = 8'h01,
  parameter logic [7:0] SUB_STAT_BASE  = 8'h10,
  parameter logic [7:0] SUB_MASK_BASE  = 8'h20,
  parameter logic [7:0] GPIO_CFG_BASE  = 8'h30
)(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [EVT_W-1:0]     evt_i,
  input  logic [NUM_GPIO-1:0]  gpio_i,
  input  logic [7:0]           addr_i,
  input  logic [DW-1:0]        wdata_i,
  input  logic                 we_i,
  input  logic                 re_i,
  output logic [DW-1:0]        rdata_o,
  output logic                 irq_o
);
  logic [7:0] stat_off, mask_off, cfg_off;
  logic       stat_sel, mask_sel;

  logic [NUM_SUB-1:0][DW-1:0]  set_vec, clr_vec, stat_q, mask_q;
  logic [NUM_SUB-1:0]          mask_we;
  logic [NUM_GPIO-1:0][DW-1:0] gpio_cfg_q;
  logic [NUM_GPIO-1:0]         gpio_hit;
  logic [NUM_MAIN-1:0]         main_stat, main_mask;
  logic                        main_mask_we;
  logic [DW-1:0]               rd_next;

  assign stat_off     = addr_i - SUB_STAT_BASE;
  assign mask_off     = addr_i - SUB_MASK_BASE;
  assign cfg_off      = addr_i - GPIO_CFG_BASE;
  assign stat_sel     = stat_off < 8'(NUM_SUB);
  assign mask_sel     = mask_off < 8'(NUM_SUB);
  assign main_mask_we = we_i && (addr_i == MAIN_MASK_ADDR);

  for (genvar s = 0; s < NUM_SUB; s++) begin : g_dec
    assign clr_vec[s] = (we_i && stat_sel && stat_off == 8'(s)) ? wdata_i : '0;
    assign mask_we[s] = we_i && mask_sel && (mask_off == 8'(s));
    if (s == GPIO_SUB) begin : g_gpio_sub
      assign set_vec[s] = evt_i[s*DW +: DW] | {{(DW-NUM_GPIO){1'b0}}, gpio_hit};
    end else begin : g_evt_sub
      assign set_vec[s] = evt_i[s*DW +: DW];
    end
  end

  for (genvar p = 0; p < NUM_GPIO; p++) begin : g_cfg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             gpio_cfg_q[p] <= '0;
      else if (we_i && cfg_off == 8'(2*p))     gpio_cfg_q[p] <= wdata_i;
    end
  end

  irqagg_gpio_detect u_detect (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (gpio_i),
    .cfg_i  (gpio_cfg_q),
    .hit_o  (gpio_hit)
  );

  irqagg_status_bank u_bank (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .set_i        (set_vec),
    .clr_i        (clr_vec),
    .mask_we_i    (mask_we),
    .mask_wdata_i (wdata_i),
    .stat_o       (stat_q),
    .mask_o       (mask_q)
  );

  irqagg_summary u_summary (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .stat_i         (stat_q),
    .mask_i         (mask_q),
    .main_mask_we_i (main_mask_we),
    .wdata_i        (wdata_i),
    .main_stat_o    (main_stat),
    .main_mask_o    (main_mask),
    .irq_o          (irq_o)
  );

  always_comb begin
    rd_next = '0;
    if (addr_i == MAIN_STAT_ADDR) rd_next = main_stat;
    if (addr_i == MAIN_MASK_ADDR) rd_next = main_mask;
    for (int s = 0; s < NUM_SUB; s++) begin
      if (stat_sel && stat_off == 8'(s)) rd_next = stat_q[s];
      if (mask_sel && mask_off == 8'(s)) rd_next = mask_q[s];
    end
    for (int p = 0; p < NUM_GPIO; p++) begin
      if (cfg_off == 8'(2*p)) rd_next = gpio_cfg_q[p];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= rd_next;
  end
endmodule

// File: rtl/irqagg_checker.sv
module irqagg_checker
  import irqagg_pkg::*;
#(
  parameter logic [7:0] SUB_STAT_BASE = 8'h10
)(
  input logic                clk_i,
  input logic                rst_ni,
  input logic [EVT_W-1:0]    evt_i,
  input logic [NUM_GPIO-1:0] gpio_i,
  input logic                we_i,
  input logic [7:0]          addr_i,
  input logic [DW-1:0]       wdata_i,
  input logic                irq_o,
  input logic [EVT_W-1:0]    sub_stat,
  input logic [DW-1:0]       main_mask,
  input logic [DW-1:0]       cfg0
);
  AST_EVENT_LATCHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i[0] |=> sub_stat[0]); // R2

  AST_NO_SILENT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ((sub_stat & $past(sub_stat)) == $past(sub_stat))); // R3

  AST_ACK_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == SUB_STAT_BASE && wdata_i == 8'hFF && evt_i[DW-1:0] == '0)
    |=> (sub_stat[DW-1:0] == '0)); // R3

  AST_MAIN_MASK_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (main_mask == 8'hFF) |-> !irq_o); // R7

  AST_PIN0_RISE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg0[6:4] == 3'b010 && gpio_i[0] && !$past(gpio_i[0])) |=> sub_stat[GPIO_SUB*DW]); // R8

  AST_PIN0_LEVEL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg0[6:4] == 3'b100 && gpio_i[0]) |=> sub_stat[GPIO_SUB*DW]); // R9
endmodule

bind irq_aggregator irqagg_checker #(.SUB_STAT_BASE(SUB_STAT_BASE)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .evt_i     (evt_i),
  .gpio_i    (gpio_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .irq_o     (irq_o),
  .sub_stat  (stat_q),
  .main_mask (main_mask),
  .cfg0      (gpio_cfg_q[0])
);

// File: tb/irq_aggregator_bench.sv
module irq_aggregator_bench;
  localparam time CLK_P = 20ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [71:0] evt = '0;
  logic [3:0]  gpio = '0;
  logic [7:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        we = 1'b0;
  logic        re = 1'b0;
  logic [7:0]  rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct { logic [7:0] val; string tag; } exp_t;
  exp_t sb[$];
  logic re_seen = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  irq_aggregator u_irq_aggregator (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .gpio_i(gpio),
    .addr_i(addr), .wdata_i(wdata), .we_i(we), .re_i(re),
    .rdata_o(rdata), .irq_o(irq)
  );

  // monitor: compare registered read data against scoreboard
  always @(posedge clk) re_seen <= re;
  always @(negedge clk) begin
    if (re_seen) begin
      exp_t e;
      checks++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL unexpected read data act=%02h exp=none", rdata);
      end else begin
        e = sb.pop_front();
        if (rdata !== e.val) begin
          fails++;
          $display("FAIL %s act=%02h exp=%02h", e.tag, rdata, e.val);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    exp_t x;
    @(negedge clk); re = 1'b1; addr = a;
    x.val = e; x.tag = tag; sb.push_back(x);
    @(negedge clk); re = 1'b0;
  endtask

  task automatic pulse(input int idx);
    @(negedge clk); evt[idx] = 1'b1;
    @(negedge clk); evt[idx] = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    @(negedge clk);
    checks++;
    if (irq !== e) begin
      fails++;
      $display("FAIL %s irq act=%0b exp=%0b", tag, irq, e);
    end
  endtask

  task automatic set_pin(input int p, input logic v);
    @(negedge clk); gpio[p] = v;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk_irq(1'b0, "R1 reset");
    rd(8'h20, 8'hFF, "R1 sub mask0");
    rd(8'h01, 8'hFF, "R1 main mask");
    rd(8'h10, 8'h00, "R1 sub stat0");
    rd(8'h36, 8'h00, "R1 cfg pin3");
    rd(8'h00, 8'h00, "R1 main stat");

    // R2 masked source still latches, R5 no main summary while masked
    pulse(3);
    rd(8'h10, 8'h08, "R2 masked latch");
    rd(8'h00, 8'h00, "R5 masked no summary");
    chk_irq(1'b0, "R2 masked no irq");

    // R5/R7 unmask sub, then main
    wr(8'h20, 8'hF7);
    rd(8'h00, 8'h01, "R5 main bit0");
    chk_irq(1'b0, "R7 main masked");
    wr(8'h01, 8'hFE);
    chk_irq(1'b1, "R7 irq asserted");

    // R3 zero bits keep value, ones clear
    wr(8'h10, 8'h00);
    rd(8'h10, 8'h08, "R3 zero write keeps");
    wr(8'h10, 8'h08);
    rd(8'h10, 8'h00, "R3 one write clears");
    chk_irq(1'b0, "R7 irq released");

    // R4 set wins over simultaneous clear
    @(negedge clk); evt[3] = 1'b1; we = 1'b1; addr = 8'h10; wdata = 8'h08;
    @(negedge clk); evt[3] = 1'b0; we = 1'b0;
    rd(8'h10, 8'h08, "R4 set wins");
    wr(8'h10, 8'h08);

    // R11 main status not writable, unmapped reads zero
    wr(8'h00, 8'hFF);
    rd(8'h00, 8'h00, "R11 main stat read only");
    rd(8'h0F, 8'h00, "R11 unmapped");

    // R6 main bit4 covers subs 4 and 5
    wr(8'h25, 8'hFD);
    wr(8'h24, 8'hFE);
    pulse(41);
    pulse(32);
    rd(8'h00, 8'h10, "R6 bit4 both");
    wr(8'h15, 8'h02);
    rd(8'h00, 8'h10, "R6 bit4 sub4 left");
    wr(8'h14, 8'h01);
    rd(8'h00, 8'h00, "R6 bit4 cleared");

    // R6 sub8 -> main bit7
    wr(8'h28, 8'hFB);
    pulse(66);
    rd(8'h00, 8'h80, "R6 sub8 to bit7");
    wr(8'h18, 8'h04);

    // R8 rising edge on pin1
    wr(8'h32, 8'h20);
    wr(8'h27, 8'hFD);
    wr(8'h01, 8'hBF);
    set_pin(1, 1'b1);
    rd(8'h17, 8'h02, "R8 rising sets");
    rd(8'h00, 8'h40, "R6 gpio main bit6");
    chk_irq(1'b1, "R8 gpio irq");
    wr(8'h17, 8'h02);
    rd(8'h17, 8'h00, "R8 steady high no reset");
    chk_irq(1'b0, "R8 irq drops");

    // R8 falling edge on pin2
    wr(8'h34, 8'h10);
    set_pin(2, 1'b1);
    rd(8'h17, 8'h00, "R8 falling ignores rise");
    set_pin(2, 1'b0);
    rd(8'h17, 8'h04, "R8 falling sets");
    wr(8'h17, 8'h04);

    // R9 level high on pin0
    set_pin(0, 1'b1);
    wr(8'h30, 8'h40);
    wr(8'h17, 8'h01);
    rd(8'h17, 8'h01, "R9 level high persists");
    set_pin(0, 1'b0);
    wr(8'h17, 8'h01);
    rd(8'h17, 8'h00, "R9 level high gone");

    // R9 level low on pin3
    wr(8'h36, 8'h50);
    rd(8'h17, 8'h08, "R9 level low sets");
    set_pin(3, 1'b1);
    wr(8'h17, 8'h08);
    rd(8'h17, 8'h00, "R9 level low gone");

    // R10 invalid code disables pin1
    wr(8'h32, 8'h30);
    set_pin(1, 1'b0);
    set_pin(1, 1'b1);
    set_pin(1, 1'b0);
    rd(8'h17, 8'h00, "R10 disabled pin");
    rd(8'h32, 8'h30, "R10 cfg readback");

    repeat (4) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R11 pending reads act=%0d exp=0", sb.size());
    end
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog act=timeout exp=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule